// File: doc/BRIEF.md
# Programmable Delayed Frame Sync Generator

This block takes the master frame sync and the data bit clock of a time-division serial bus and produces a set of delayed sync strobes. Each strobe is a copy of the master sync moved later by its own programmed number of data clock cycles. Several voice codecs can share one serial data pair this way, with each codec given its own strobe and so its own time slot. For example, with 10-bit slots, delays of 0, 10, 20 and 40 mark slots that do not overlap.

The block runs directly on the data clock. It does not create any timing of its own; every frame starts from a rising edge of the master sync. One frame counter is shared by all channels. Each channel has a small state machine with three states:

- `ST_IDLE`: no sync has been seen since reset.
- `ST_ARMED`: the delay is still counting.
- `ST_SPENT`: the strobe has been given for this frame.

Its transitions are:

- *start*: a sync rising edge with a nonzero delay, going to `ST_ARMED`.
- *zero-start*: a sync rising edge with a zero delay, going to `ST_SPENT` and firing at once.
- *fire*: in `ST_ARMED`, when the count reaches the delay, going to `ST_SPENT`.
- *restart*: any sync rising edge while in `ST_ARMED` or `ST_SPENT`. It re-enters through start or zero-start.

Register writes go to a staging copy. The channel takes that copy only on the next sync rising edge.

Top module: `dsync_gen`

## Requirements
- R1: After reset all strobes are low, every delay register reads as zero, and no strobe rises until the first master sync rising edge.
- R2: For a delay D > 0, the channel gives its strobe exactly D data clock cycles after the cycle in which the master sync is first seen high.
- R3: A delay of zero gives the strobe in the same cycle as the master sync rising edge.
- R4: Each strobe is one data clock cycle wide and appears at most once per frame.
- R5: Every channel counts independently from the same master sync, each with its own 16-bit delay selected by `wr_sel` (channel index i written when `wr_sel` equals i and `wr_en` is high).
- R6: A write takes effect at the next master sync rising edge. A frame already running keeps the delay it started with.
- R7: A master sync rising edge that arrives before a pending strobe has fired restarts the count from the new edge, and the pending strobe is dropped.
- R8: Only a low-to-high change of the master sync starts a frame. Holding the sync high for several cycles does not start it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dclk | input | 1 | Data bit clock of the serial bus; the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Master frame sync from the line transceiver |
| wr_en | input | 1 | Delay register write strobe |
| wr_sel | input | 2 | Channel index of the register written |
| wr_data | input | 16 | Delay value, in data clock cycles |
| dsync | output | 4 | Delayed sync strobes, one bit per channel |

## Verification
The main function is tried with sets of four delays. These include:

- the codec-slot spacing 0/10/20/40 and its permutation, which separate per-channel register selection from a shared value;
- small consecutive delays (1, 2, 3), which expose off-by-one counting;
- identical delays on every channel, which show that channels do not suppress one another.

Directed frames then cover three further cases:

- a write in the middle of a frame, which separates staged loading from immediate loading;
- a second sync before a pending strobe, which separates restart from completion;
- a sync held high, which separates edge start from level start.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SPENT = 2'd2
    } ch_state_t;
endpackage

// File: rtl/dsync_frame_counter.sv
module dsync_frame_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic             rise,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic fsync_q;

    assign rise = fsync & ~fsync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsync_q <= 1'b0;
            cnt     <= '0;
        end else begin
            fsync_q <= fsync;
            if (rise)
                cnt <= CNT_W'(1);
            else if (cnt != '0 && cnt != CNT_MAX)
                cnt <= cnt + CNT_W'(1);
        end
    end

    // R7: a sync edge always restarts the count at one
    p_restart_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cnt == CNT_W'(1)));

    // R2: between edges the count advances by exactly one per data clock
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && cnt != '0 && cnt != CNT_MAX) |=> ((cnt - $past(cnt)) == CNT_W'(1)));
endmodule

// File: rtl/dsync_channel.sv
module dsync_channel
    import dsync_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] staged,
    output logic             fire
);
    ch_state_t        state, state_nx;
    logic [CNT_W-1:0] active;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_SPENT: begin
                if (rise) state_nx = (staged == '0) ? ST_SPENT : ST_ARMED;
            end
            ST_ARMED: begin
                if (rise)               state_nx = (staged == '0) ? ST_SPENT : ST_ARMED;
                else if (cnt == active) state_nx = ST_SPENT;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            active <= '0;
        end else begin
            state <= state_nx;
            if (rise) active <= staged;
        end
    end

    always_comb begin
        fire = 1'b0;
        unique case (state)
            ST_IDLE, ST_SPENT: fire = rise && (staged == '0);
            ST_ARMED:          fire = rise ? (staged == '0) : (cnt == active);
            default:           fire = 1'b0;
        endcase
    end

    // R1: nothing fires before the first sync edge
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !rise) |-> !fire);

    // R4: a strobe lasts one cycle unless a fresh frame begins
    p_one_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!fire || rise));

    // R6: the delay in use only changes on a sync edge
    p_hold_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(active));
endmodule

// File: rtl/dsync_gen.sv
module dsync_gen #(
    parameter int NUM_OUT = 4,
    parameter int DLY_W   = 16,
    localparam int SEL_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic               dclk,
    input  logic               rst_n,
    input  logic               fsync,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [DLY_W-1:0]   wr_data,
    output logic [NUM_OUT-1:0] dsync
);
    logic             rise;
    logic [DLY_W-1:0] cnt;
    logic [DLY_W-1:0] staged [NUM_OUT];

    dsync_frame_counter #(.CNT_W(DLY_W)) u_cnt (
        .clk   (dclk),
        .rst_n (rst_n),
        .fsync (fsync),
        .rise  (rise),
        .cnt   (cnt)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
        always_ff @(posedge dclk or negedge rst_n) begin
            if (!rst_n)
                staged[i] <= '0;
            else if (wr_en && wr_sel == SEL_W'(i))
                staged[i] <= wr_data;
        end

        dsync_channel #(.CNT_W(DLY_W)) u_ch (
            .clk    (dclk),
            .rst_n  (rst_n),
            .rise   (rise),
            .cnt    (cnt),
            .staged (staged[i]),
            .fire   (dsync[i])
        );

        // R3: a zero delay fires with the sync edge itself
        p_zero_delay_r3: assert property (@(posedge dclk) disable iff (!rst_n)
            (rise && staged[i] == '0) |-> dsync[i]);
    end

    // R8: a sync that stays high never opens a frame
    p_level_no_start_r8: assert property (@(posedge dclk) disable iff (!rst_n)
        $past(fsync) |-> !rise);
endmodule

// File: tb/tb_dsync_gen.sv
module tb_dsync_gen;
    localparam int N = 4;

    logic        dclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [N-1:0] dsync;

    int checks = 0;
    int failures = 0;
    int pos [N];
    int hits [N];

    always #2.5 dclk = ~dclk;

    dsync_gen dut (
        .dclk(dclk), .rst_n(rst_n), .fsync(fsync),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .dsync(dsync)
    );

    localparam int VEC [5][N] = '{
        '{0, 10, 20, 40},
        '{20, 40, 0, 10},
        '{1, 2, 3, 63},
        '{5, 5, 5, 5},
        '{30, 31, 32, 33}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int val);
        @(negedge dclk);
        wr_en = 1'b1; wr_sel = 2'(ch); wr_data = 16'(val);
        @(posedge dclk); #1;
        wr_en = 1'b0;
    endtask

    // fsync high for cycles [0,hold) and at cycle resync; optional write at cycle wat
    task automatic frame(input int len, input int hold, input int resync,
                         input int wat, input int wch, input int wval);
        for (int k = 0; k < N; k++) begin pos[k] = -1; hits[k] = 0; end
        for (int c = 0; c < len; c++) begin
            @(negedge dclk);
            fsync = (c < hold) || (c == resync);
            wr_en = (c == wat); wr_sel = 2'(wch); wr_data = 16'(wval);
            #1;
            for (int k = 0; k < N; k++)
                if (dsync[k]) begin
                    if (pos[k] < 0) pos[k] = c;
                    hits[k]++;
                end
        end
        @(negedge dclk);
        fsync = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state and silence before first sync
        #1;
        chk(dsync == '0, "R1 in reset", int'(dsync), 0);
        repeat (3) @(negedge dclk);
        rst_n = 1'b1;
        wr(0, 7);
        frame(20, 0, -1, -1, 0, 0);
        for (int k = 0; k < N; k++) chk(hits[k] == 0, "R1 no sync no strobe", hits[k], 0);
        wr(0, 0);
        // R1: registers reset to zero -> all fire with the sync
        frame(10, 1, -1, -1, 0, 0);
        for (int k = 0; k < N; k++) chk(pos[k] == 0, "R1 zero after reset", pos[k], 0);

        // R2 R3 R4 R5: table walk
        for (int v = 0; v < 5; v++) begin
            for (int k = 0; k < N; k++) wr(k, VEC[v][k]);
            frame(70, 1, -1, -1, 0, 0);
            for (int k = 0; k < N; k++) begin
                chk(pos[k] == VEC[v][k], VEC[v][k] == 0 ? "R3 zero delay position" : "R2 R5 delay position",
                    pos[k], VEC[v][k]);
                chk(hits[k] == 1, "R4 one pulse per frame", hits[k], 1);
            end
        end

        // R6: mid-frame write applies at next sync only
        for (int k = 0; k < N; k++) wr(k, 10);
        frame(40, 1, -1, 3, 0, 25);
        chk(pos[0] == 10, "R6 old delay kept this frame", pos[0], 10);
        frame(40, 1, -1, -1, 0, 0);
        chk(pos[0] == 25, "R6 new delay next frame", pos[0], 25);
        chk(pos[1] == 10, "R5 other channel untouched", pos[1], 10);

        // R7: resync before pending strobe
        wr(0, 30);
        frame(60, 1, 15, -1, 0, 0);
        chk(pos[0] == 45, "R7 restart position", pos[0], 45);
        chk(hits[0] == 1, "R7 pending dropped", hits[0], 1);

        // R8: sync held high for 5 cycles
        wr(2, 2);
        frame(30, 5, -1, -1, 0, 0);
        chk(pos[2] == 2, "R8 edge start position", pos[2], 2);
        chk(hits[2] == 1, "R8 no retrigger on level", hits[2], 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule